// File: doc/BRIEF.md
# Multi-mode hit trigger controller

This block turns sixteen already-shaped channel hit bits into one internal trigger. A mode field picks how the hits are judged. Coincidence mode fires when every channel in a mask is hit in the same clock. Sum mode fires when the number of hit channels in a clock reaches a threshold. In table mode the raw hit pattern is sent to an external lookup memory, which answers with a one-bit verdict. Window mode gathers the masked hits over a programmable number of clocks and then sends the gathered pattern to that memory.

An issued trigger starts an output pulse of programmable length and adds one to a free-running trigger count. The pulse cannot be restarted while it is running. Two control bits gate it onto the front-panel pin. Configuration is written through a small select/data port and can be read back on the same select.

Mode, masks, window width and threshold are frozen while the disable bit is clear. Sum mode stays live even with the disable bit set. The host bus decode, the lookup memory and the per-channel hit shaping sit outside the block.

Top module: `hit_trig_ctrl`

## Requirements
- R1: After reset, trig_fp is 0 and trig_count is 0. The mode register (select 0) reads 0x0008, meaning table mode with the disable bit (bit 3) set. The output width (select 5) reads 4.
- R2: The mode field is bits [2:0] of select 0, coded 0 table, 1 coincidence, 2 window, 4 sum. A write carrying 3, 5, 6 or 7 leaves the mode unchanged.
- R3: A zero write to the coincidence mask (select 1), the window mask (select 2), the window width (select 3) or the sum threshold (select 4) is ignored. Their reset values are 0xFFFF, 0xFFFF, 1 and 1.
- R4: While the disable bit is 0, writes to the mode field, both masks, the window width and the threshold are ignored. The disable bit itself stays writable.
- R5: In coincidence mode with the disable bit clear, a clock in which all channels of the coincidence mask are hit starts a pulse on the next clock. A clock that misses any masked channel does not.
- R6: In table mode with the disable bit clear, a clock with a nonzero hit pattern raises lut_req for one clock on the next cycle, with lut_addr equal to that pattern. A trigger is issued when lut_hit is 1 in that cycle. An all-zero pattern makes no request.
- R7: In window mode with the disable bit clear, the first clock with a masked hit opens a window of W clocks, where W is the window width. The OR of the masked hits over those W clocks is presented on lut_addr, with lut_req high, in the clock after the window. A trigger is issued if lut_hit is 1 in that clock. Hits outside the window mask open no window.
- R8: In sum mode, a clock whose count of hit channels is at least the threshold issues a trigger. This holds even while the disable bit is set, and status bit 4 (live) then reads 1.
- R9: In table, coincidence or window mode with the disable bit set, no trigger is issued and trig_count does not change.
- R10: A write to the output width (select 5) is clamped to OUT_MAX (200 by default). A write of 0 leaves the previous value in place.
- R11: The output pulse lasts exactly the programmed width in clocks. Trigger conditions that arrive while it runs are dropped and do not change trig_count.
- R12: trig_count rises by one for each issued trigger. trig_fp shows the pulse only when both bit 0 (live enable) and bit 1 (front-panel enable) of select 6 are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hits | input | 16 | Shaped hit bit per channel |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select for write and read |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data of the selected register |
| lut_req | output | 1 | Lookup request, one clock |
| lut_addr | output | 16 | Pattern to look up |
| lut_hit | input | 1 | Lookup verdict, valid while lut_req is high |
| trig_fp | output | 1 | Gated front-panel trigger pulse |
| trig_count | output | 32 | Issued trigger count |
| status | output | 16 | [2:0] mode, [3] disable, [4] live, [5] pulse busy, [6] window open, [15:8] version |

## Verification
The bench writes the illegal mode codes 3 and 6 and checks that the mode is kept; a design that decoded the field as contiguous would change it. It attacks the lock by writing masks and modes while armed; a design that ignored the lock would read back the new values. It repeats a coincidence during a running pulse and looks for a second pulse or a count of two; a retriggerable pulse would show both. It checks that sum mode fires with the disable bit set and that the other modes stay silent with it set. It checks that the window pattern includes a hit from the last window clock but not an unmasked hit; a window off by one clock, or a missing mask, would present a different address.

// File: rtl/hit_trig_pkg.sv
package hit_trig_pkg;

    typedef enum logic [2:0] {
        MODE_TABLE  = 3'd0,
        MODE_COIN   = 3'd1,
        MODE_WINDOW = 3'd2,
        MODE_SUM    = 3'd4
    } trig_mode_e;

    typedef enum logic [2:0] {
        SEL_MODE   = 3'd0,
        SEL_CMASK  = 3'd1,
        SEL_WMASK  = 3'd2,
        SEL_WWIDTH = 3'd3,
        SEL_THRESH = 3'd4,
        SEL_OWIDTH = 3'd5,
        SEL_OCTRL  = 3'd6
    } cfg_sel_e;

    function automatic logic mode_is_legal(input logic [2:0] m);
        return (m == MODE_TABLE) || (m == MODE_COIN) ||
               (m == MODE_WINDOW) || (m == MODE_SUM);
    endfunction

endpackage

// File: rtl/htc_cfg_regs.sv
module htc_cfg_regs
    import hit_trig_pkg::*;
#(
    parameter int NCH     = 16,
    parameter int TW      = 16,
    parameter int OUT_MAX = 200,
    parameter int OUT_RST = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [2:0]     sel,
    input  logic [15:0]    wdata,
    output logic [15:0]    rdata,
    output logic [2:0]     mode,
    output logic           dis,
    output logic [NCH-1:0] cmask,
    output logic [NCH-1:0] wmask,
    output logic [TW-1:0]  wwidth,
    output logic [15:0]    thresh,
    output logic [TW-1:0]  owidth,
    output logic           live_en,
    output logic           fp_en
);
    typedef struct packed {
        logic [2:0]     mode;
        logic           dis;
        logic [NCH-1:0] cmask;
        logic [NCH-1:0] wmask;
        logic [TW-1:0]  wwidth;
        logic [15:0]    thr;
        logic [TW-1:0]  owidth;
        logic           live;
        logic           fp;
    } cfg_t;

    cfg_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (we) begin
            case (sel)
                SEL_MODE: begin
                    c_d.dis = wdata[3];
                    if (c_q.dis && mode_is_legal(wdata[2:0]))
                        c_d.mode = wdata[2:0];
                end
                SEL_CMASK:
                    if (c_q.dis && wdata[NCH-1:0] != '0) c_d.cmask = wdata[NCH-1:0];
                SEL_WMASK:
                    if (c_q.dis && wdata[NCH-1:0] != '0) c_d.wmask = wdata[NCH-1:0];
                SEL_WWIDTH:
                    if (c_q.dis && wdata[TW-1:0] != '0) c_d.wwidth = wdata[TW-1:0];
                SEL_THRESH:
                    if (c_q.dis && wdata != '0) c_d.thr = wdata;
                SEL_OWIDTH:
                    if (wdata[TW-1:0] != '0)
                        c_d.owidth = (wdata[TW-1:0] > TW'(OUT_MAX)) ? TW'(OUT_MAX)
                                                                    : wdata[TW-1:0];
                SEL_OCTRL: begin
                    c_d.live = wdata[0];
                    c_d.fp   = wdata[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.mode   <= MODE_TABLE;
            c_q.dis    <= 1'b1;
            c_q.cmask  <= '1;
            c_q.wmask  <= '1;
            c_q.wwidth <= TW'(1);
            c_q.thr    <= 16'd1;
            c_q.owidth <= TW'(OUT_RST);
            c_q.live   <= 1'b0;
            c_q.fp     <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_MODE:   rdata = {12'd0, c_q.dis, c_q.mode};
            SEL_CMASK:  rdata = 16'(c_q.cmask);
            SEL_WMASK:  rdata = 16'(c_q.wmask);
            SEL_WWIDTH: rdata = 16'(c_q.wwidth);
            SEL_THRESH: rdata = c_q.thr;
            SEL_OWIDTH: rdata = 16'(c_q.owidth);
            SEL_OCTRL:  rdata = {14'd0, c_q.fp, c_q.live};
            default:    rdata = '0;
        endcase
    end

    assign mode    = c_q.mode;
    assign dis     = c_q.dis;
    assign cmask   = c_q.cmask;
    assign wmask   = c_q.wmask;
    assign wwidth  = c_q.wwidth;
    assign thresh  = c_q.thr;
    assign owidth  = c_q.owidth;
    assign live_en = c_q.live;
    assign fp_en   = c_q.fp;

    assert_mode_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_is_legal(c_q.mode));

    assert_nonzero_cfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.cmask != '0) && (c_q.wmask != '0) && (c_q.wwidth != '0) && (c_q.thr != '0));

    assert_locked_when_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !c_q.dis |=> $stable(c_q.mode) && $stable(c_q.cmask) && $stable(c_q.wmask)
                     && $stable(c_q.wwidth) && $stable(c_q.thr));

    assert_width_clamped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.owidth != '0) && (c_q.owidth <= TW'(OUT_MAX)));

endmodule

// File: rtl/htc_window.sv
module htc_window #(
    parameter int NCH = 16,
    parameter int TW  = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [NCH-1:0] hits_m,
    input  logic [TW-1:0]  width,
    output logic           req,
    output logic [NCH-1:0] addr,
    output logic           busy
);
    typedef struct packed {
        logic           busy;
        logic [TW-1:0]  cnt;
        logic [NCH-1:0] acc;
        logic           req;
        logic [NCH-1:0] addr;
    } win_t;

    win_t w_d, w_q;

    always_comb begin
        w_d     = w_q;
        w_d.req = 1'b0;
        if (!run) begin
            w_d.busy = 1'b0;
            w_d.acc  = '0;
            w_d.cnt  = '0;
        end else if (!w_q.busy) begin
            if (hits_m != '0) begin
                if (width == TW'(1)) begin
                    w_d.req  = 1'b1;
                    w_d.addr = hits_m;
                end else begin
                    w_d.busy = 1'b1;
                    w_d.cnt  = width - TW'(1);
                    w_d.acc  = hits_m;
                end
            end
        end else begin
            w_d.acc = w_q.acc | hits_m;
            w_d.cnt = w_q.cnt - TW'(1);
            if (w_q.cnt == TW'(1)) begin
                w_d.req  = 1'b1;
                w_d.addr = w_q.acc | hits_m;
                w_d.busy = 1'b0;
                w_d.acc  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign req  = w_q.req;
    assign addr = w_q.addr;
    assign busy = w_q.busy;

    assert_window_addr_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.req |-> (w_q.addr != '0));

    assert_window_req_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.req |=> !w_q.req || $past(run));

endmodule

// File: rtl/htc_pulse.sv
module htc_pulse #(
    parameter int TW = 16,
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic [TW-1:0] width,
    output logic          active,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [TW-1:0] cnt;
        logic [CW-1:0] total;
    } pulse_t;

    pulse_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (p_q.cnt != '0) begin
            p_d.cnt = p_q.cnt - TW'(1);
        end else if (fire) begin
            p_d.cnt   = width;
            p_d.total = p_q.total + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign active = (p_q.cnt != '0);
    assign count  = p_q.total;

    assert_no_retrigger_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.cnt != '0) |=> (p_q.total == $past(p_q.total)));

    assert_count_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && p_q.cnt == '0) |=> (p_q.total == $past(p_q.total) + CW'(1)) && active);

endmodule

// File: rtl/hit_trig_ctrl.sv
module hit_trig_ctrl
    import hit_trig_pkg::*;
#(
    parameter int NCH     = 16,
    parameter int TW      = 16,
    parameter int CW      = 32,
    parameter int OUT_MAX = 200,
    parameter int OUT_RST = 4,
    parameter int VERSION = 8'h21
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] hits,
    input  logic           cfg_we,
    input  logic [2:0]     cfg_sel,
    input  logic [15:0]    cfg_wdata,
    output logic [15:0]    cfg_rdata,
    output logic           lut_req,
    output logic [NCH-1:0] lut_addr,
    input  logic           lut_hit,
    output logic           trig_fp,
    output logic [CW-1:0]  trig_count,
    output logic [15:0]    status
);
    localparam int PW = $clog2(NCH + 1);

    logic [2:0]     mode;
    logic           dis;
    logic [NCH-1:0] cmask, wmask;
    logic [TW-1:0]  wwidth, owidth;
    logic [15:0]    thresh;
    logic           live_en, fp_en;

    htc_cfg_regs #(.NCH(NCH), .TW(TW), .OUT_MAX(OUT_MAX), .OUT_RST(OUT_RST)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .rdata(cfg_rdata), .mode(mode), .dis(dis), .cmask(cmask), .wmask(wmask),
        .wwidth(wwidth), .thresh(thresh), .owidth(owidth),
        .live_en(live_en), .fp_en(fp_en)
    );

    logic live;
    assign live = !dis || (mode == MODE_SUM);

    // Hit counter for the sum mode, one adder per channel.
    logic [PW-1:0] part [NCH+1];
    assign part[0] = '0;
    for (genvar g = 0; g < NCH; g++) begin : g_ones
        assign part[g+1] = part[g] + PW'(hits[g]);
    end

    // Table-mode request register.
    typedef struct packed {
        logic           req;
        logic [NCH-1:0] addr;
    } tbl_t;

    tbl_t t_d, t_q;

    always_comb begin
        t_d     = t_q;
        t_d.req = 1'b0;
        if (live && mode == MODE_TABLE && hits != '0) begin
            t_d.req  = 1'b1;
            t_d.addr = hits;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    logic           win_req, win_busy;
    logic [NCH-1:0] win_addr;

    htc_window #(.NCH(NCH), .TW(TW)) u_win (
        .clk(clk), .rst_n(rst_n),
        .run(live && mode == MODE_WINDOW),
        .hits_m(hits & wmask), .width(wwidth),
        .req(win_req), .addr(win_addr), .busy(win_busy)
    );

    assign lut_req  = (mode == MODE_WINDOW) ? win_req  : t_q.req;
    assign lut_addr = (mode == MODE_WINDOW) ? win_addr : t_q.addr;

    logic fire;
    always_comb begin
        fire = 1'b0;
        if (live) begin
            case (mode)
                MODE_COIN:   fire = ((hits & cmask) == cmask);
                MODE_SUM:    fire = (16'(part[NCH]) >= thresh);
                MODE_TABLE,
                MODE_WINDOW: fire = lut_req && lut_hit;
                default:     fire = 1'b0;
            endcase
        end
    end

    logic active;

    htc_pulse #(.TW(TW), .CW(CW)) u_pulse (
        .clk(clk), .rst_n(rst_n), .fire(fire), .width(owidth),
        .active(active), .count(trig_count)
    );

    assign trig_fp = active && live_en && fp_en;
    assign status  = {8'(VERSION), 1'b0, win_busy, active, live, dis, mode};

    assert_fp_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
        trig_fp |-> (live_en && fp_en));

    assert_disabled_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dis && mode != MODE_SUM) |=> (trig_count == $past(trig_count)));

    assert_table_req_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_TABLE && lut_req) |-> (lut_addr != '0));

endmodule

// File: tb/hit_trig_ctrl_tb.sv
module hit_trig_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] hits;
    logic        cfg_we;
    logic [2:0]  cfg_sel;
    logic [15:0] cfg_wdata;
    logic [15:0] cfg_rdata;
    logic        lut_req;
    logic [15:0] lut_addr;
    logic        lut_hit;
    logic        trig_fp;
    logic [31:0] trig_count;
    logic [15:0] status;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Lookup table model: a pattern is a valid trigger when channel 4 is in it.
    assign lut_hit = lut_req && lut_addr[4];

    hit_trig_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .hits(hits),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .lut_req(lut_req), .lut_addr(lut_addr), .lut_hit(lut_hit),
        .trig_fp(trig_fp), .trig_count(trig_count), .status(status)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int exp_pulse [$];
    int hi_len   = 0;
    logic done   = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: measures each front-panel pulse and compares it to the queue.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (trig_fp) begin
                hi_len++;
            end else if (hi_len != 0) begin
                n_checks++;
                if (exp_pulse.size() == 0) begin
                    n_fail++;
                    $display("FAIL R11/R12 pulse: actual width %0d expected no pulse", hi_len);
                end else begin
                    int w;
                    w = exp_pulse.pop_front();
                    if (w != hi_len) begin
                        n_fail++;
                        $display("FAIL R11 pulse width: actual %0d expected %0d", hi_len, w);
                    end
                end
                hi_len = 0;
            end
        end
    end

    task automatic wr(input logic [2:0] sel, input logic [15:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [15:0] data);
        cfg_sel = sel;
        #1;
        data = cfg_rdata;
    endtask

    task automatic step(input logic [15:0] h);
        hits = h;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        hits = '0;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        rst_n = 1'b0; hits = '0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 trig_fp", 32'(trig_fp), 0);
        check("R1 count", trig_count, 0);
        rd(3'd0, r); check("R1 mode reg", 32'(r), 32'h8);
        rd(3'd5, r); check("R1 out width", 32'(r), 4);

        // R2 illegal mode codes
        wr(3'd0, 16'h000B); rd(3'd0, r); check("R2 code 3 kept", 32'(r), 32'h8);
        wr(3'd0, 16'h000E); rd(3'd0, r); check("R2 code 6 kept", 32'(r), 32'h8);
        wr(3'd0, 16'h000C); rd(3'd0, r); check("R2 code 4 taken", 32'(r), 32'hC);

        // R3 zero writes ignored
        wr(3'd1, 16'h0000); rd(3'd1, r); check("R3 cmask", 32'(r), 32'hFFFF);
        wr(3'd3, 16'h0000); rd(3'd3, r); check("R3 wwidth", 32'(r), 1);
        wr(3'd4, 16'h0000); rd(3'd4, r); check("R3 thresh", 32'(r), 1);

        // R10 output width
        wr(3'd5, 16'h0000); rd(3'd5, r); check("R10 zero kept", 32'(r), 4);
        wr(3'd5, 16'hFFFF); rd(3'd5, r); check("R10 clamp", 32'(r), 200);
        wr(3'd5, 16'h0003); rd(3'd5, r); check("R10 set 3", 32'(r), 3);

        // Coincidence setup, then arm
        wr(3'd1, 16'h0005);
        wr(3'd6, 16'h0003);
        wr(3'd0, 16'h0001);
        rd(3'd0, r); check("R2 code 1 armed", 32'(r), 32'h1);

        // R4 lock while armed
        wr(3'd1, 16'h00FF); rd(3'd1, r); check("R4 cmask locked", 32'(r), 32'h5);
        wr(3'd0, 16'h0004); rd(3'd0, r); check("R4 mode locked", 32'(r), 32'h1);

        // R5 coincidence
        step(16'h0001); idle(1);
        check("R5 partial no trigger", trig_count, 0);
        exp_pulse.push_back(3);
        step(16'h0007); hits = '0;
        check("R5 trig_fp raised", 32'(trig_fp), 1);
        check("R12 count 1", trig_count, 1);
        idle(5);

        // R11 no retrigger
        exp_pulse.push_back(3);
        step(16'h0005); step(16'h0005); idle(5);
        check("R11 count once", trig_count, 2);

        // R12 front-panel gating
        wr(3'd6, 16'h0001);
        step(16'h0005);
        hits = '0;
        check("R12 gated low", 32'(trig_fp), 0);
        idle(5);
        check("R12 counted while gated", trig_count, 3);
        wr(3'd6, 16'h0003);

        // R9 disabled coincidence
        wr(3'd0, 16'h0009);
        step(16'hFFFF); hits = '0;
        check("R9 no pulse", 32'(trig_fp), 0);
        idle(3);
        check("R9 count kept", trig_count, 3);

        // R8 sum mode with disable bit set
        wr(3'd4, 16'h0003);
        wr(3'd0, 16'h000C);
        check("R8 live status", 32'(status[4]), 1);
        step(16'h0003); idle(1);
        check("R8 below threshold", trig_count, 3);
        exp_pulse.push_back(3);
        step(16'h0007); idle(5);
        check("R8 at threshold", trig_count, 4);

        // R6 table mode
        wr(3'd0, 16'h0008);
        wr(3'd0, 16'h0000);
        exp_pulse.push_back(3);
        step(16'h0012); hits = '0;
        check("R6 req", 32'(lut_req), 1);
        check("R6 addr", 32'(lut_addr), 32'h12);
        @(negedge clk);
        check("R6 hit triggers", trig_count, 5);
        idle(5);
        step(16'h0001); hits = '0;
        check("R6 addr 1", 32'(lut_addr), 32'h1);
        @(negedge clk);
        check("R6 miss no trigger", trig_count, 5);
        check("R6 zero no req", 32'(lut_req), 0);

        // R7 window mode
        wr(3'd0, 16'h0008);
        wr(3'd2, 16'h00F0);
        wr(3'd3, 16'h0003);
        wr(3'd0, 16'h0002);
        exp_pulse.push_back(3);
        step(16'h0010);
        check("R7 open no req", 32'(lut_req), 0);
        step(16'h0100);
        step(16'h0020); hits = '0;
        check("R7 req after window", 32'(lut_req), 1);
        check("R7 gathered addr", 32'(lut_addr), 32'h30);
        @(negedge clk);
        check("R7 trigger", trig_count, 6);
        idle(5);
        step(16'h0F00); hits = '0;
        check("R7 unmasked no window", 32'(status[6]), 0);
        idle(4);
        check("R7 count kept", trig_count, 6);

        check("R11 all pulses seen", exp_pulse.size(), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule